// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block collects the interrupt conditions of one UART channel and turns them into one interrupt request line and a six-bit identification code. The code always names the single most urgent source that is both pending and enabled. Sources of lower urgency wait behind it and are not lost. When the source on top is serviced, the next one in line shows up in the code.

There are four enable bits. Bit 0 enables received data and receive timeout, which share one priority level. Bit 1 enables transmit holding empty. Bit 2 enables line status. Bit 3 enables both the modem status change and the CTS/RTS change. The CTS/RTS change sits at the very bottom of the order.

Each servicing action arrives as a one-cycle strobe:
- a status register read,
- a receive holding read,
- a transmit holding write,
- a read of the identification code itself.

The holding register is empty out of reset, so the transmit-empty source starts out pending. It is reported as soon as its enable bit is set.

Top module: `uart_irq_arbiter`

## Requirements
- R1: When no enabled source is pending, `irq` is low and `iid` equals 6'h01.
- R2: A `line_err_evt` pulse latches a line status source. It is reported as 6'h06 above every other source, and `lsr_rd` clears it. A clear and an event in the same cycle leave the source clear.
- R3: While `rx_at_level` is high and `ier[0]` is set, and no line status source is enabled and pending, `iid` is 6'h04. This source follows the input level and has no latch.
- R4: A `rx_idle_evt` pulse latches a receive timeout, and `rhr_rd` clears it. The timeout is reported as 6'h0C only when the receive level source is not active, because the two share a level and the level code wins.
- R5: The transmit-empty source is set by a rising edge of `thr_empty` and is reported as 6'h02 below the receive level. It is cleared by `thr_wr`, or by `iid_rd` while 6'h02 is the reported code. A clear wins over a set in the same cycle.
- R6: Out of reset the transmit-empty source is pending. With `ier[1]` set and nothing else pending, `iid` is 6'h02 right away.
- R7: A `modem_evt` pulse latches a modem status source. It is reported as 6'h00 below transmit empty, and `msr_rd` clears it.
- R8: A `cts_chg_evt` or `rts_chg_evt` pulse latches a flow-control change source. It is enabled by `ier[3]`, reported as 6'h20 only when every other source is clear or masked, and cleared by `iid_rd` while 6'h20 is reported.
- R9: Clearing an enable bit masks its source without discarding it. When the bit is set again, the source is reported.
- R10: `irq` is high exactly when bit 0 of `iid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Enables: 0 rx/timeout, 1 tx empty, 2 line status, 3 modem and flow |
| rx_at_level | input | 1 | Receive FIFO count at or above trigger level |
| rx_idle_evt | input | 1 | Receive timeout event pulse |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| line_err_evt | input | 1 | Line status error event pulse |
| lsr_rd | input | 1 | Line status read strobe |
| modem_evt | input | 1 | Modem status change event pulse |
| msr_rd | input | 1 | Modem status read strobe |
| cts_chg_evt | input | 1 | CTS change event pulse |
| rts_chg_evt | input | 1 | RTS change event pulse |
| iid_rd | input | 1 | Identification code read strobe |
| irq | output | 1 | Interrupt request |
| iid | output | 6 | Identification code of the top pending source |

## Verification
A pending flag that is stuck set shows up as a code that does not change after its clear strobe, one cycle after that strobe. A flag that never latches shows up as a source that never appears, or as a lower code showing through in the cycle after the event pulse. A wrong ordering or a wrong clear condition on read changes the code in the first cycle where two sources overlap. Random overlap of events, clears and enable changes reaches these cases within a few dozen cycles.

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic       rx_at_level,
  input  logic       rx_idle_evt,
  input  logic       thr_empty,
  input  logic       thr_wr,
  input  logic       rhr_rd,
  input  logic       line_err_evt,
  input  logic       lsr_rd,
  input  logic       modem_evt,
  input  logic       msr_rd,
  input  logic       cts_chg_evt,
  input  logic       rts_chg_evt,
  input  logic       iid_rd,
  output logic       irq,
  output logic [5:0] iid
);
  localparam logic [5:0] ID_NONE = 6'h01;
  localparam logic [5:0] ID_LINE = 6'h06;
  localparam logic [5:0] ID_RXLV = 6'h04;
  localparam logic [5:0] ID_RXTO = 6'h0C;
  localparam logic [5:0] ID_THRE = 6'h02;
  localparam logic [5:0] ID_MDM  = 6'h00;
  localparam logic [5:0] ID_FLOW = 6'h20;

  logic line_p, tout_p, thre_p, thr_q, mdm_p, flow_p;

  wire act_line = line_p & ier[2];
  wire act_rxlv = rx_at_level & ier[0];
  wire act_rxto = tout_p & ier[0];
  wire act_thre = thre_p & ier[1];
  wire act_mdm  = mdm_p & ier[3];
  wire act_flow = flow_p & ier[3];

  always_comb begin
    if (act_line)      iid = ID_LINE;
    else if (act_rxlv) iid = ID_RXLV;
    else if (act_rxto) iid = ID_RXTO;
    else if (act_thre) iid = ID_THRE;
    else if (act_mdm)  iid = ID_MDM;
    else if (act_flow) iid = ID_FLOW;
    else               iid = ID_NONE;
  end

  assign irq = act_line | act_rxlv | act_rxto | act_thre | act_mdm | act_flow;

  wire thre_clr = thr_wr | (iid_rd & (iid == ID_THRE));
  wire flow_clr = iid_rd & (iid == ID_FLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_p <= 1'b0;
      tout_p <= 1'b0;
      thre_p <= 1'b1;
      thr_q  <= 1'b1;
      mdm_p  <= 1'b0;
      flow_p <= 1'b0;
    end else begin
      line_p <= !lsr_rd && (line_p || line_err_evt);
      tout_p <= !rhr_rd && (tout_p || rx_idle_evt);
      thre_p <= !thre_clr && (thre_p || (thr_empty && !thr_q));
      thr_q  <= thr_empty;
      mdm_p  <= !msr_rd && (mdm_p || modem_evt);
      flow_p <= !flow_clr && (flow_p || cts_chg_evt || rts_chg_evt);
    end
  end
endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier,
  input logic       line_err_evt,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic       irq,
  input logic [5:0] iid
);
  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> iid == 6'h01);
  p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_err_evt && !lsr_rd |=> (iid == 6'h06) || !ier[2]);
  p_thre_gone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> iid != 6'h02);
  p_flow_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iid == 6'h20 |-> ier[3]);
  p_irq_bit0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !iid[0]);
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (.*);

// File: tb/uart_irq_arbiter_bench.sv
`timescale 1ns/1ps
module uart_irq_arbiter_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] ier = 0;
  logic rx_at_level = 0, rx_idle_evt = 0, thr_empty = 1, thr_wr = 0, rhr_rd = 0;
  logic line_err_evt = 0, lsr_rd = 0, modem_evt = 0, msr_rd = 0;
  logic cts_chg_evt = 0, rts_chg_evt = 0, iid_rd = 0;
  logic irq;
  logic [5:0] iid;
  int tests = 0, fails = 0;
  bit m_line, m_tout, m_thre, m_thrq, m_mdm, m_flow;

  always #2 clk = ~clk;

  uart_irq_arbiter u_uart_irq_arbiter (.*);

  function automatic logic [5:0] exp_id();
    if (m_line && ier[2])           return 6'h06;
    if (rx_at_level && ier[0])      return 6'h04;
    if (m_tout && ier[0])           return 6'h0C;
    if (m_thre && ier[1])           return 6'h02;
    if (m_mdm && ier[3])            return 6'h00;
    if (m_flow && ier[3])           return 6'h20;
    return 6'h01;
  endfunction

  function automatic string tag_of(logic [5:0] c);
    case (c)
      6'h06: return "R2";
      6'h04: return "R3";
      6'h0C: return "R4";
      6'h02: return "R5";
      6'h00: return "R7";
      6'h20: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag);
    logic [5:0] e = exp_id();
    tests++;
    if (iid !== e) begin
      fails++;
      $display("FAIL %s iid actual=%h expected=%h", (tag == "") ? tag_of(e) : tag, iid, e);
    end
    tests++;
    if (irq !== (e != 6'h01)) begin
      fails++;
      $display("FAIL R10 irq actual=%b expected=%b", irq, e != 6'h01);
    end
  endtask

  task automatic step(string tag);
    logic [5:0] e;
    #1 check(tag);
    @(posedge clk);
    e = exp_id();
    m_line = !lsr_rd && (m_line || line_err_evt);
    m_tout = !rhr_rd && (m_tout || rx_idle_evt);
    m_thre = !(thr_wr || (iid_rd && e == 6'h02)) && (m_thre || (thr_empty && !m_thrq));
    m_thrq = thr_empty;
    m_mdm  = !msr_rd && (m_mdm || modem_evt);
    m_flow = !(iid_rd && e == 6'h20) && (m_flow || cts_chg_evt || rts_chg_evt);
    @(negedge clk);
    {rx_idle_evt, thr_wr, rhr_rd, line_err_evt, lsr_rd, modem_evt, msr_rd} = '0;
    {cts_chg_evt, rts_chg_evt, iid_rd} = '0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    m_line = 0; m_tout = 0; m_thre = 1; m_thrq = 1; m_mdm = 0; m_flow = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1");                        // reset, nothing enabled
    ier = 4'b0010; step("R6");         // tx empty pending from reset
    iid_rd = 1; step("R5");            // read clears tx empty
    step("R1");
    ier = 4'b0000; line_err_evt = 1; step("R9");
    ier = 4'b0100; step("R9");         // masked source reappears
    ier = 4'b1111; cts_chg_evt = 1; modem_evt = 1; step("R2");
    lsr_rd = 1; step("R2");
    step("R7");
    msr_rd = 1; step("R7");
    step("R8");
    rx_idle_evt = 1; step("R8");
    rx_at_level = 1; step("R4");
    step("R3");
    rx_at_level = 0; rhr_rd = 1; step("R4");
    iid_rd = 1; step("R8");
    step("R1");
    line_err_evt = 1; lsr_rd = 1; step("R2");  // clear wins
    step("R1");
    thr_empty = 0; step("R5");
    thr_empty = 1; thr_wr = 1; step("R5");     // clear wins over edge
    step("R5");
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) ier = 4'($urandom);
      if ($urandom % 6 == 0) rx_at_level = ~rx_at_level;
      if ($urandom % 7 == 0) thr_empty = ~thr_empty;
      rx_idle_evt  = ($urandom % 9 == 0);
      line_err_evt = ($urandom % 11 == 0);
      modem_evt    = ($urandom % 9 == 0);
      cts_chg_evt  = ($urandom % 12 == 0);
      rts_chg_evt  = ($urandom % 12 == 0);
      thr_wr       = ($urandom % 8 == 0);
      rhr_rd       = ($urandom % 6 == 0);
      lsr_rd       = ($urandom % 5 == 0);
      msr_rd       = ($urandom % 6 == 0);
      iid_rd       = ($urandom % 3 == 0);
      step("");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule